// File: doc/BRIEF.md
# Constrained Clock Ratio Control Register

This block keeps the clock division settings for six on-chip clock domains, all of them fed from one source clock: peripheral, display (LCD), CPU, DSP, bus traffic controller (TC) and the DSP memory-management unit (MMU). Each domain has a 2-bit exponent `e`, and that domain runs at the source rate divided by `2^e`, so by 1, 2, 4 or 8. The setting is held in one 16-bit register. Software writes the register through a strobe and a data word. Software reads it back through a read bus that is always driven.

A written word is not stored as given. A combinational sanitiser first adjusts the dependent exponents so that the domain rates stay legal. The DSP-MMU clock must run at the DSP rate or at half of it. The bus clock may not be faster than the CPU clock or the DSP-MMU clock. The display and peripheral clocks may not be faster than the bus clock. The CPU and DSP exponents, and the upper four bits, are stored exactly as written.

Each domain has a power-of-two divider that produces a one-cycle clock-enable pulse in the source clock domain. A divider switches to a new exponent only at its own terminal count. A pulse interval therefore never comes out shorter than the old or the new period.

Top module: `ckr_ratio_ctrl`

## Requirements
- R1: After reset the register reads 0x0000 and all six enable outputs are high on every source clock cycle.
- R2: Field layout and divider outputs:
  - Exponent fields: peripheral [1:0], LCD [3:2], CPU [5:4], DSP [7:6], TC [9:8], DSP-MMU [11:10].
  - Enable bit order: `dom_en[i]` belongs to the field at bits [2i+1:2i].
  - Divider rate: once settled, a domain with stored exponent e pulses exactly once every 2^e source cycles.
- R3: A stored DSP-MMU exponent is never below the DSP exponent and never above the DSP exponent plus one. A lower written value is raised to the DSP exponent. A higher written value is lowered to the DSP exponent plus one.
- R4: The stored TC exponent is the largest of three values: the written TC exponent, the CPU exponent, and the already adjusted DSP-MMU exponent.
- R5: The stored LCD and peripheral exponents are each raised to at least the final TC exponent. A written value that is already larger is kept.
- R6: The CPU and DSP exponents are stored exactly as written.
- R7: Bits [15:12] of a written word are stored unchanged.
- R8: The read bus returns the sanitised stored value. Without a write strobe, the stored value does not change, whatever is on the write data bus.
- R9: A domain adopts a new exponent only at its current terminal count. When a domain changes from exponent 3 to 0 just after a pulse, it shows seven low cycles, then a pulse, then continuous pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock shared by all domains |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe; the sanitised `wr_data` is stored on this edge |
| wr_data | input | 16 | Requested register value |
| rd_data | output | 16 | Stored (sanitised) register value |
| dom_en | output | 6 | Per-domain clock-enable pulses: 0 peripheral, 1 LCD, 2 CPU, 3 DSP, 4 TC, 5 DSP-MMU |

## Verification
A wrong clamp in the sanitiser shows on the read bus in the cycle right after the write. The same error also shows as a wrong pulse count on the affected enable output, at the latest about 8 cycles later, once that divider reaches its terminal count. A divider that loads its exponent away from the terminal count shows as a pulse interval that differs from both the old and the new period. The bench therefore measures the gap around an exponent change cycle by cycle. It also counts pulses over a 64-cycle window for each domain.

// File: rtl/ckr_pkg.sv
package ckr_pkg;
  localparam int REG_W   = 16;
  localparam int EXP_W   = 2;
  localparam int NUM_DOM = 6;
  localparam int TOP_LSB = NUM_DOM * EXP_W;

  localparam int D_PER = 0;
  localparam int D_LCD = 1;
  localparam int D_CPU = 2;
  localparam int D_DSP = 3;
  localparam int D_TC  = 4;
  localparam int D_MMU = 5;

  typedef logic [EXP_W-1:0] exp_t;
  typedef exp_t [NUM_DOM-1:0] exp_vec_t;
endpackage

// File: rtl/ckr_sanitize.sv
module ckr_sanitize
  import ckr_pkg::*;
(
  input  logic [REG_W-1:0] raw,
  output logic [REG_W-1:0] clean
);
  exp_vec_t req;
  exp_vec_t fix;
  logic [EXP_W:0] dsp_plus1;

  // Split the word into one exponent per domain
  always_comb begin
    for (int i = 0; i < NUM_DOM; i++) begin
      req[i] = raw[i*EXP_W +: EXP_W];
    end
  end

  // The clamps run in order; each one uses the results of the ones before it
  always_comb begin
    fix       = req;
    dsp_plus1 = {1'b0, req[D_DSP]} + 1'b1;
    if (fix[D_MMU] < fix[D_DSP]) fix[D_MMU] = fix[D_DSP];
    if ({1'b0, fix[D_MMU]} > dsp_plus1) fix[D_MMU] = dsp_plus1[EXP_W-1:0];
    if (fix[D_TC] < fix[D_CPU]) fix[D_TC] = fix[D_CPU];
    if (fix[D_TC] < fix[D_MMU]) fix[D_TC] = fix[D_MMU];
    if (fix[D_LCD] < fix[D_TC]) fix[D_LCD] = fix[D_TC];
    if (fix[D_PER] < fix[D_TC]) fix[D_PER] = fix[D_TC];
  end

  always_comb begin
    clean = raw;
    for (int i = 0; i < NUM_DOM; i++) begin
      clean[i*EXP_W +: EXP_W] = fix[i];
    end
  end
endmodule

// File: rtl/ckr_pow2_div.sv
module ckr_pow2_div #(
  parameter int EXP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXP_W-1:0] exp_in,
  output logic             en_out
);
  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int CNT_W   = (MAX_EXP < 1) ? 1 : MAX_EXP;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXP_W-1:0] act_q, act_d;
  logic [CNT_W-1:0] limit;
  logic             term;

  assign limit  = ~({CNT_W{1'b1}} << act_q);
  assign term   = (cnt_q == limit);
  assign en_out = term;

  // A new exponent is loaded only at terminal count, so no short interval appears
  always_comb begin
    cnt_d = cnt_q + 1'b1;
    act_d = act_q;
    if (term) begin
      cnt_d = '0;
      act_d = exp_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit) else $error("count beyond limit"); // R2

  AST_EXP_SWITCH_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(term) |-> $stable(act_q)) else $error("exponent moved mid-period"); // R9

  AST_RESTART_AFTER_TC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(term) |-> (cnt_q == '0)) else $error("no restart after terminal"); // R9
endmodule

// File: rtl/ckr_ratio_ctrl.sv
module ckr_ratio_ctrl
  import ckr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  output logic [NUM_DOM-1:0] dom_en
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [REG_W-1:0] clean;
  logic [REG_W-1:0] cfg_q, cfg_d;

  // Reset asserts at once and is released two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ckr_sanitize u_sanitize (
    .raw   (wr_data),
    .clean (clean)
  );

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = clean;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) cfg_q <= '0;
    else            cfg_q <= cfg_d;
  end

  assign rd_data = cfg_q;

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    ckr_pow2_div #(.EXP_W(EXP_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .exp_in (cfg_q[g*EXP_W +: EXP_W]),
      .en_out (dom_en[g])
    );
  end

  AST_MMU_WINDOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_q[D_MMU*EXP_W +: EXP_W] >= cfg_q[D_DSP*EXP_W +: EXP_W]) &&
    ({1'b0, cfg_q[D_MMU*EXP_W +: EXP_W]} <= {1'b0, cfg_q[D_DSP*EXP_W +: EXP_W]} + 3'd1))
    else $error("mmu outside dsp window"); // R3

  AST_TC_FLOOR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_q[D_TC*EXP_W +: EXP_W] >= cfg_q[D_CPU*EXP_W +: EXP_W]) &&
    (cfg_q[D_TC*EXP_W +: EXP_W] >= cfg_q[D_MMU*EXP_W +: EXP_W]))
    else $error("tc faster than cpu or mmu"); // R4

  AST_SLOW_DOMAINS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_q[D_LCD*EXP_W +: EXP_W] >= cfg_q[D_TC*EXP_W +: EXP_W]) &&
    (cfg_q[D_PER*EXP_W +: EXP_W] >= cfg_q[D_TC*EXP_W +: EXP_W]))
    else $error("lcd or per faster than tc"); // R5

  AST_CPU_DSP_KEPT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(wr_en) |-> (cfg_q[D_CPU*EXP_W +: 2*EXP_W] == $past(wr_data[D_CPU*EXP_W +: 2*EXP_W])))
    else $error("cpu/dsp altered"); // R6

  AST_TOP_PASS: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(wr_en) |-> (cfg_q[REG_W-1:TOP_LSB] == $past(wr_data[REG_W-1:TOP_LSB])))
    else $error("upper bits altered"); // R7

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$past(wr_en) |-> $stable(cfg_q)) else $error("register changed without write"); // R8
endmodule

// File: tb/ckr_ratio_ctrl_test.sv
`timescale 1ns/1ps
module ckr_ratio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [5:0]  dom_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ckr_ratio_ctrl uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .dom_en  (dom_en)
  );

  localparam int NV = 10;
  localparam logic [15:0] V_IN [NV] = '{
    16'h0000, 16'hF000, 16'h0080, 16'h0C00, 16'h0030,
    16'h011E, 16'hA840, 16'hFFFF, 16'h5555, 16'h00CC };
  localparam logic [15:0] V_EXP [NV] = '{
    16'h0000, 16'hF000, 16'h0A8A, 16'h0505, 16'h033F,
    16'h011E, 16'hAA4A, 16'hFFFF, 16'h5555, 16'h0FCF };
  localparam string V_TAG [NV] = '{
    "R1", "R7", "R3", "R3", "R4", "R5", "R4", "R7", "R6", "R5" };

  task automatic check(string tag, int act, int exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp_v);
    end
  endtask

  task automatic do_write(logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_rates(logic [15:0] stored);
    int cnt [6];
    for (int k = 0; k < 6; k++) cnt[k] = 0;
    repeat (16) @(negedge clk);
    repeat (64) begin
      @(negedge clk);
      for (int k = 0; k < 6; k++) cnt[k] += int'(dom_en[k]);
    end
    for (int k = 0; k < 6; k++)
      check("R2 pulse count", cnt[k], 64 >> stored[2*k +: 2]);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int gap;
    logic [15:0] held;
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_data = 16'h0000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset value and divide-by-1 on every domain
    check("R1 reset read", rd_data, 16'h0000);
    for (int k = 0; k < 4; k++) begin
      check("R1 enables high", dom_en, 6'h3F);
      @(negedge clk);
    end

    for (int i = 0; i < NV; i++) begin
      do_write(V_IN[i]);
      check(V_TAG[i], rd_data, V_EXP[i]);
      check_rates(V_EXP[i]);
    end

    // R8: data without strobe is ignored
    held = rd_data;
    @(negedge clk);
    wr_data = 16'h1234;
    repeat (20) @(negedge clk);
    check("R8 hold", rd_data, held);

    // R9: exponent 3 -> 0 takes effect only at next terminal count
    do_write(16'h0FFF);
    check("R8 read back", rd_data, 16'h0FFF);
    repeat (16) @(negedge clk);
    while (!dom_en[2]) @(negedge clk);
    @(negedge clk);
    gap = 0;
    if (!dom_en[2]) gap++;
    wr_en = 1'b1;
    wr_data = 16'h0000;
    @(negedge clk);
    wr_en = 1'b0;
    while (!dom_en[2] && gap < 20) begin
      gap++;
      @(negedge clk);
    end
    check("R9 low gap", gap, 7);
    @(negedge clk);
    check("R9 next pulse", dom_en[2], 1);

    // R1: a fresh reset clears the register again
    do_write(16'h5555);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 re-reset read", rd_data, 16'h0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule